// File: doc/BRIEF.md
# HDLC Receive Deframer

This block recovers HDLC frames from a serial bit stream. A one-cycle strobe on `bit_en` marks each line bit. The block looks for the 0x7E flag pattern and drops the zero that the sender inserts after five ones. It assembles the remaining bits into bytes, least significant bit first, and checks the 16-bit frame check sequence over each frame. It also recognises the abort pattern.

Every assembled byte goes to the host through a single holding register. The register holds the byte value, a valid strobe, an end-of-frame flag and an error flag. The host takes a byte by pulsing `rd_ack`. When a frame closes, the host first gets its data bytes, then the two checksum bytes as they were received, and then one status byte with end-of-frame set. A good frame gives status 0x00 with the error flag clear. A bad checksum or malformed frame gives 0x7E with the error flag set. An abort gives 0xFF with the error flag set.

When the error flag is set on the status byte, the host discards the whole frame. The block then goes on to the next frame by itself.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `byte_valid`, `byte_eof` and `byte_err` are 0 and `byte_data` is 0x00.
- R2: Between an opening and a closing 0x7E flag, each complete group of 8 received data bits appears on `byte_data`, least significant bit first, with `byte_valid` 1 and `byte_eof` 0, in arrival order.
- R3: A 0 that follows five consecutive 1s on the line is removed and never enters a data byte.
- R4: At a closing flag, the two checksum bytes (low byte first, as received) have already been delivered as ordinary bytes, and one status byte with `byte_eof` 1 follows them.
- R5: The check is CRC-16 (polynomial x^16+x^12+x^5+1, reflected, preset 0xFFFF) over all received bytes including the checksum. A residue of 0xF0B8 with no other fault gives status 0x00 and `byte_err` 0.
- R6: Any other residue gives status 0x7E with `byte_err` 1.
- R7: Seven consecutive 1s inside a frame that has received data give status 0xFF with `byte_eof` 1 and `byte_err` 1. A partly assembled byte is dropped. All later bits are ignored until the next flag.
- R8: A frame of fewer than 4 bytes (checksum included) gives status 0x7E with `byte_err` 1.
- R9: A closing flag that arrives when the data bit count is not a multiple of 8 gives status 0x7E with `byte_err` 1.
- R10: If a new byte is ready while the previous one is still valid and not acknowledged, the new byte overwrites it with `byte_err` 1. The frame's status byte then also carries `byte_err` 1.
- R11: Consecutive flags, including flags that share a 0, produce no byte and no end-of-frame.
- R12: `rd_ack` clears `byte_valid`. The frame after a closing flag is received without any host action, and that flag also serves as the next frame's opening flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a valid line bit |
| rx_bit | input | 1 | Serial line bit, sampled when `bit_en` is 1 |
| rd_ack | input | 1 | Host read pulse, clears `byte_valid` |
| byte_data | output | 8 | Received byte or frame status code |
| byte_valid | output | 1 | Holding register contains an unread byte |
| byte_eof | output | 1 | Byte is the frame's final status byte |
| byte_err | output | 1 | Receive error: overrun, bad check, short, misaligned or abort |

## Verification
The bench sends payloads full of 1s, such as 0xFF, 0x7E and 0x1F. A design that failed to remove stuffed zeros, or removed the wrong bits, would then shift every later byte and also fail the checksum. Frames are sent back to back over one shared flag, and runs of idle flags are sent alone. A design that treated a flag pair as an empty frame would emit spurious end-of-frame bytes.

The bench also drives aborts in mid-byte, frames that are too short or not byte-aligned, and a host that stops reading. Each of these must show the 0xFF or 0x7E code with the error flag set. A design that missed one of these cases would hand a damaged frame to the host as good.

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter logic [15:0] CRC_GOOD  = 16'hF0B8,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter int          MIN_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       rd_ack,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       byte_eof,
  output logic       byte_err
);
  localparam int CW = $clog2(MIN_BYTES + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_BYTES);

  logic [2:0]    ones_q;
  logic          in_frame_q;
  logic [6:0]    pipe_q;
  logic [2:0]    pipe_n_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_n_q;
  logic [CW-1:0] byte_n_q;
  logic [15:0]   crc_q;
  logic          ovr_q;

  // line pattern decode
  wire is_flag  = bit_en & ~rx_bit & (ones_q == 3'd6);
  wire is_stuff = bit_en & ~rx_bit & (ones_q == 3'd5);
  wire is_abort = bit_en &  rx_bit & (ones_q == 3'd6);
  wire push     = bit_en & in_frame_q & ~is_flag & ~is_stuff & ~is_abort;
  wire pop      = push & (pipe_n_q == 3'd7);
  wire pop_bit  = pipe_q[0];

  wire       byte_done = pop & (bit_n_q == 3'd7);
  wire [7:0] new_byte  = {pop_bit, sh_q[7:1]};

  wire has_data = (byte_n_q != '0) | (bit_n_q != 3'd0);
  wire end_ev   = is_flag  & in_frame_q & has_data;
  wire abort_ev = is_abort & in_frame_q & has_data;
  wire ev       = byte_done | end_ev | abort_ev;
  wire coll     = ev & byte_valid & ~rd_ack;

  wire crc_ok  = (crc_q == CRC_GOOD);
  wire len_ok  = (byte_n_q >= CMAX);
  wire algn_ok = (bit_n_q == 3'd0);
  wire frm_ok  = crc_ok & len_ok & algn_ok;

  wire [7:0] stat_data = abort_ev ? 8'hFF : (frm_ok ? 8'h00 : 8'h7E);
  wire       stat_err  = abort_ev | ~frm_ok | ovr_q | coll;

  wire        fb       = crc_q[0] ^ pop_bit;
  wire [15:0] crc_step = (crc_q >> 1) ^ (fb ? CRC_POLY : 16'h0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= 3'd0;
    end else if (bit_en) begin
      if (!rx_bit)               ones_q <= 3'd0;
      else if (ones_q != 3'd7)   ones_q <= ones_q + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      pipe_q     <= 7'd0;
      pipe_n_q   <= 3'd0;
      sh_q       <= 8'd0;
      bit_n_q    <= 3'd0;
      byte_n_q   <= '0;
      crc_q      <= 16'hFFFF;
      ovr_q      <= 1'b0;
    end else if (is_flag) begin
      in_frame_q <= 1'b1;
      pipe_n_q   <= 3'd0;
      bit_n_q    <= 3'd0;
      byte_n_q   <= '0;
      crc_q      <= 16'hFFFF;
      ovr_q      <= 1'b0;
    end else if (is_abort) begin
      in_frame_q <= 1'b0;
    end else if (push) begin
      pipe_q <= {rx_bit, pipe_q[6:1]};
      if (pipe_n_q != 3'd7) pipe_n_q <= pipe_n_q + 3'd1;
      if (pop) begin
        sh_q    <= new_byte;
        bit_n_q <= bit_n_q + 3'd1;
        crc_q   <= crc_step;
        if (byte_done && byte_n_q != CMAX) byte_n_q <= byte_n_q + 1'b1;
        if (coll) ovr_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_data  <= 8'd0;
      byte_valid <= 1'b0;
      byte_eof   <= 1'b0;
      byte_err   <= 1'b0;
    end else if (ev) begin
      byte_data  <= byte_done ? new_byte : stat_data;
      byte_eof   <= ~byte_done;
      byte_err   <= byte_done ? (coll | ovr_q) : stat_err;
      byte_valid <= 1'b1;
    end else if (rd_ack) begin
      byte_valid <= 1'b0;
    end
  end

  a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && rd_ack && !ev) |=> !byte_valid);

  a_r10_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> (byte_valid && byte_err));

  a_r5_good_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_eof && !byte_err) |-> (byte_data == 8'h00));

  a_r6_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_eof) |-> (byte_data == 8'h00 || byte_data == 8'h7E || byte_data == 8'hFF));

  a_r7_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (byte_eof && byte_err && byte_data == 8'hFF));

  a_r11_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (is_flag && !has_data && !rd_ack) |=> $stable(byte_valid));

  a_r3_stuff_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    is_stuff |=> $stable(pipe_n_q));
endmodule

// File: tb/hdlc_rx_deframer_tb_top.sv
module hdlc_rx_deframer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, rd_ack = 1'b0;
  logic [7:0] byte_data;
  logic byte_valid, byte_eof, byte_err;

  always #2 clk = ~clk;

  hdlc_rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .rd_ack(rd_ack),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_eof(byte_eof), .byte_err(byte_err)
  );

  // {len, b0, b1, b2, b3, fcs_low_xor_mask}
  localparam logic [47:0] VEC [5] = '{
    {8'd3, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00},
    {8'd4, 8'hFF, 8'h7E, 8'h1F, 8'hF8, 8'h00},
    {8'd4, 8'h01, 8'h02, 8'h03, 8'h04, 8'h01},
    {8'd2, 8'hA5, 8'h5A, 8'h00, 8'h00, 8'h00},
    {8'd4, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h80}
  };

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit read_en = 1'b1;
  int tx_ones = 0;
  logic [7:0] cap_d [64];
  logic       cap_f [64];
  logic       cap_e [64];
  int cap_n = 0;
  logic [7:0] exp_d [64];
  logic       exp_f [64];
  logic       exp_e [64];
  int exp_n = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic send_raw(input bit b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    if (byte_valid && read_en) begin
      if (cap_n < 64) begin
        cap_d[cap_n] = byte_data; cap_f[cap_n] = byte_eof; cap_e[cap_n] = byte_err;
      end
      cap_n++;
      rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
    end
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw(i != 0 && i != 7);
    tx_ones = 0;
  endtask

  task automatic send_dbit(input bit b);
    send_raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_dbit(v[i]);
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] v);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ v[i]) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  task automatic add_exp(input logic [7:0] d, input bit f, input bit e);
    exp_d[exp_n] = d; exp_f[exp_n] = f; exp_e[exp_n] = e; exp_n++;
  endtask

  // sends data and checksum (no flags); records expected bytes
  task automatic send_body(input logic [7:0] b [4], input int len, input logic [7:0] mask);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    for (int i = 0; i < len; i++) begin
      c = crc_upd(c, b[i]); send_byte(b[i]); add_exp(b[i], 1'b0, 1'b0);
    end
    fcs = ~c;
    send_byte(fcs[7:0] ^ mask);  add_exp(fcs[7:0] ^ mask, 1'b0, 1'b0);
    send_byte(fcs[15:8]);        add_exp(fcs[15:8], 1'b0, 1'b0);
  endtask

  task automatic verify(input string req);
    chk(cap_n == exp_n, {req, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_d[i] == exp_d[i], {req, " data"}, cap_d[i], exp_d[i]);
      chk(cap_f[i] == exp_f[i], {req, " eof"},  cap_f[i], exp_f[i]);
      chk(cap_e[i] == exp_e[i], {req, " err"},  cap_e[i], exp_e[i]);
    end
    cap_n = 0; exp_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] pl [4];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(byte_valid == 1'b0 && byte_eof == 1'b0 && byte_err == 1'b0, "R1 reset flags",
        {byte_valid, byte_eof, byte_err}, 0);
    chk(byte_data == 8'h00, "R1 reset data", byte_data, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R12: table of frames sharing one flag between neighbours
    send_flag();
    for (int v = 0; v < 5; v++) begin
      for (int k = 0; k < 4; k++) pl[k] = VEC[v][39-8*k -: 8];
      send_body(pl, int'(VEC[v][47:40]), VEC[v][7:0]);
      send_flag();
      if (VEC[v][7:0] != 8'h00) add_exp(8'h7E, 1'b1, 1'b1);
      else                      add_exp(8'h00, 1'b1, 1'b0);
    end
    verify("R2 R3 R4 R5 R6 R12 table");
    chk(byte_valid == 1'b0, "R12 ack clears valid", byte_valid, 0);

    // R11 repeated flags and shared-zero flags give nothing
    send_flag(); send_flag();
    for (int i = 0; i < 7; i++) send_raw(i != 6);
    for (int i = 0; i < 7; i++) send_raw(i != 6);
    verify("R11 idle flags");

    // R7 abort mid-frame, then ignored bits, then recovery
    send_byte(8'h11); send_byte(8'h22);
    add_exp(8'h11, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_raw(1'b1);
    add_exp(8'hFF, 1'b1, 1'b1);
    send_raw(0); send_raw(0); for (int i = 0; i < 4; i++) send_raw(1'b1);
    send_raw(0); send_raw(0); send_raw(1); send_raw(1);
    verify("R7 abort");
    send_flag();
    pl[0] = 8'h3C; pl[1] = 8'hC3; pl[2] = 8'h00; pl[3] = 8'h00;
    send_body(pl, 2, 8'h00); send_flag(); add_exp(8'h00, 1'b1, 1'b0);
    verify("R7 R12 recovery after abort");

    // R8 short frame: 1 data + 2 checksum bytes
    pl[0] = 8'h42;
    send_body(pl, 1, 8'h00); send_flag(); add_exp(8'h7E, 1'b1, 1'b1);
    verify("R8 short frame");

    // R9 misaligned closing flag
    pl[0] = 8'h42; pl[1] = 8'h43;
    send_body(pl, 2, 8'h00);
    send_dbit(0); send_dbit(0); send_dbit(0);
    send_flag(); add_exp(8'h7E, 1'b1, 1'b1);
    verify("R9 misaligned");

    // R10 overrun: host stops reading for a whole frame
    read_en = 1'b0;
    pl[0] = 8'h10; pl[1] = 8'h20; pl[2] = 8'h30; pl[3] = 8'h40;
    send_body(pl, 4, 8'h00); send_flag();
    exp_n = 0;
    @(negedge clk);
    chk(byte_valid == 1'b1, "R10 status held", byte_valid, 1);
    chk(byte_data == 8'h00 && byte_eof == 1'b1, "R10 status data", {byte_eof, byte_data}, 9'h100);
    chk(byte_err == 1'b1, "R10 overrun err", byte_err, 1);
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    chk(byte_valid == 1'b0, "R12 ack after overrun", byte_valid, 0);
    read_en = 1'b1;

    // R12 next frame clean after overrun frame
    pl[0] = 8'h5A; pl[1] = 8'hA5; pl[2] = 8'h7E;
    send_body(pl, 3, 8'h00); send_flag(); add_exp(8'h00, 1'b1, 1'b0);
    verify("R10 R12 frame after overrun");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule